// File: doc/BRIEF.md
# Chainable Serial Shift Slice

This block is a 32-bit shift register driven by a capture clock that arrives on an external pin and is gated by an external qualifier pin. The system clock `clk` samples both pins through a short synchronizer. A selected transition of the pin clock that arrives while the qualifier is active counts as a qualified edge. On each qualified edge the register shifts either one bit or one whole byte. New data enters at the most significant end. The least significant byte is the parallel output.

The data shifted in can come from three places: the external data pins, the register's own low byte (a self-loop), or a neighbouring slice's output byte. The neighbour source lets several slices form one long shift path. Each slice also keeps a shadow word. When a full 32 bits have been shifted in, the freshly filled word moves into the shadow, the previous shadow becomes the working register, and a one-cycle swap pulse is raised. A clear strobe on the configuration port zeroes both words and the fill count. The mode fields are static levels.

Top module: `chain_shift_slice`

## Requirements
- R1: After reset, `dout_o` is 0x00 and `swap_o` is low.
- R2: With `cfg_par8_i`=1, each qualified edge moves the primary word down by 8 bits and places the source byte in bits [31:24]. `dout_o` always shows bits [7:0] of the primary word.
- R3: With `cfg_par8_i`=0, each qualified edge moves the primary word down by one bit and places bit 0 of the source byte in bit 31. The other source bits have no effect, and a swap happens after exactly 32 such edges.
- R4: On the edge that completes 32 shifted bits (four byte shifts in byte mode), the primary word takes the old shadow word and the shadow takes the just-filled word. `swap_o` is high for exactly one `clk` cycle, and the fill count restarts at zero.
- R5: A pin-clock edge that arrives while the effective qualifier is low is ignored: it changes neither the words nor the fill count.
- R6: With `cfg_qual_inv_i`=0 the qualifier is active high. With `cfg_qual_inv_i`=1 it is active low.
- R7: With `cfg_cap_fall_i`=0 the register shifts on rising edges of `ext_clk_i`. With `cfg_cap_fall_i`=1 it shifts on falling edges only.
- R8: With `cfg_link_en_i`=0 the source byte is `pin_data_i`. With `cfg_link_en_i`=1 and `cfg_link_ord_i`=0 it is the slice's own bits [7:0] (self-loop).
- R9: With `cfg_link_en_i`=1 and `cfg_link_ord_i` equal to 1, 2 or 3, the source byte is `chain_in_i` from the neighbouring slice, and `pin_data_i` has no effect.
- R10: A one-cycle `cfg_clr_i` zeroes the primary word, the shadow word and the fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_clk_i | input | 1 | External capture clock pin |
| qual_i | input | 1 | External qualifier pin |
| pin_data_i | input | 8 | External data pins |
| chain_in_i | input | 8 | Output byte of the neighbouring slice |
| cfg_par8_i | input | 1 | 1: byte per edge, 0: bit per edge |
| cfg_cap_fall_i | input | 1 | 1: falling pin-clock edge, 0: rising |
| cfg_qual_inv_i | input | 1 | 1: qualifier active low |
| cfg_link_en_i | input | 1 | 1: internal source (self or neighbour), 0: pins |
| cfg_link_ord_i | input | 2 | 0: self-loop, 1 to 3: neighbour chain |
| cfg_clr_i | input | 1 | Clear strobe for both words and the fill count |
| dout_o | output | 8 | Low byte of the primary word |
| swap_o | output | 1 | One-cycle pulse on each primary/shadow swap |

## Verification
The bench builds the block with its defaults: a 32-bit word, a byte width of 8 and two synchronizer stages. With these values a swap takes four byte shifts or 32 single-bit shifts. Each fill and swap cycle therefore needs only a few dozen qualified edges, so the bench can run several complete cycles in both widths. It can also read back the shadow contents through `dout_o` after a second swap. The short synchronizer keeps each pin-clock phase to a handful of `clk` cycles, so ignored edges, inverted qualifiers and falling-edge capture can each be exercised next to a swap boundary.

// File: rtl/slice_pkg.sv
package slice_pkg;

  // Source selection when the internal link is enabled
  typedef enum logic [1:0] {
    LINK_SELF  = 2'd0,
    LINK_PAIR  = 2'd1,
    LINK_QUAD  = 2'd2,
    LINK_OCTET = 2'd3
  } link_ord_e;

  typedef struct packed {
    logic      par8;
    logic      cap_fall;
    logic      qual_inv;
    logic      link_en;
    link_ord_e link_ord;
  } slice_cfg_t;

endpackage

// File: rtl/slice_edge_det.sv
module slice_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_i,
  input  logic qual_i,
  input  logic cap_fall_i,
  input  logic qual_inv_i,
  output logic fire_o
);

  logic [SYNC_STAGES-1:0] ck_sync_q, ck_sync_d;
  logic [SYNC_STAGES-1:0] qu_sync_q, qu_sync_d;
  logic                   ck_prev_q, ck_prev_d;
  logic                   rise, fall, qual_eff;

  always_comb begin
    ck_sync_d = {ck_sync_q[SYNC_STAGES-2:0], ext_clk_i};
    qu_sync_d = {qu_sync_q[SYNC_STAGES-2:0], qual_i};
    ck_prev_d = ck_sync_q[SYNC_STAGES-1];
    rise      = ck_sync_q[SYNC_STAGES-1] & ~ck_prev_q;
    fall      = ~ck_sync_q[SYNC_STAGES-1] & ck_prev_q;
    qual_eff  = qu_sync_q[SYNC_STAGES-1] ^ qual_inv_i;
    fire_o    = qual_eff & (cap_fall_i ? fall : rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sync_q <= '0;
      qu_sync_q <= '0;
      ck_prev_q <= 1'b0;
    end else begin
      ck_sync_q <= ck_sync_d;
      qu_sync_q <= qu_sync_d;
      ck_prev_q <= ck_prev_d;
    end
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o); // R7

endmodule

// File: rtl/slice_src_mux.sv
module slice_src_mux
  import slice_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              link_en_i,
  input  link_ord_e         link_ord_i,
  input  logic [BYTE_W-1:0] pin_i,
  input  logic [BYTE_W-1:0] self_i,
  input  logic [BYTE_W-1:0] chain_i,
  output logic [BYTE_W-1:0] byte_o
);

  always_comb begin
    if (!link_en_i)                  byte_o = pin_i;
    else if (link_ord_i == LINK_SELF) byte_o = self_i;
    else                             byte_o = chain_i;
  end

endmodule

// File: rtl/slice_shift_core.sv
module slice_shift_core #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              clr_i,
  input  logic              par8_i,
  input  logic [BYTE_W-1:0] byte_in_i,
  output logic [BYTE_W-1:0] low_byte_o,
  output logic              swap_o
);

  localparam int CW = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] prim_q, prim_d, shad_q, shad_d, shifted;
  logic [CW-1:0]     cnt_q, cnt_d, step, sum;
  logic              swap_q, swap_d, wrap;

  always_comb begin
    step    = par8_i ? CW'(BYTE_W) : CW'(1);
    sum     = cnt_q + step;
    wrap    = (sum >= CW'(WORD_W));
    shifted = par8_i ? {byte_in_i, prim_q[WORD_W-1:BYTE_W]}
                     : {byte_in_i[0], prim_q[WORD_W-1:1]};
    prim_d  = prim_q;
    shad_d  = shad_q;
    cnt_d   = cnt_q;
    swap_d  = 1'b0;
    if (clr_i) begin
      prim_d = '0;
      shad_d = '0;
      cnt_d  = '0;
    end else if (shift_i) begin
      if (wrap) begin
        prim_d = shad_q;
        shad_d = shifted;
        cnt_d  = '0;
        swap_d = 1'b1;
      end else begin
        prim_d = shifted;
        cnt_d  = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
      shad_q <= '0;
      cnt_q  <= '0;
      swap_q <= 1'b0;
    end else begin
      prim_q <= prim_d;
      shad_q <= shad_d;
      cnt_q  <= cnt_d;
      swap_q <= swap_d;
    end
  end

  assign low_byte_o = prim_q[BYTE_W-1:0];
  assign swap_o     = swap_q;

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !clr_i) |=> ($stable(prim_q) && $stable(shad_q) && $stable(cnt_q))); // R5
  AST_BYTE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i && par8_i && !wrap) |=> (prim_q[WORD_W-1 -: BYTE_W] == $past(byte_in_i))); // R2
  AST_SWAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    swap_q |=> !swap_q); // R4
  AST_SWAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    swap_q |-> (cnt_q == '0)); // R4
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (prim_q == '0 && shad_q == '0 && cnt_q == '0)); // R10
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(WORD_W)); // R4

endmodule

// File: rtl/chain_shift_slice.sv
module chain_shift_slice
  import slice_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_i,
  input  logic              qual_i,
  input  logic [BYTE_W-1:0] pin_data_i,
  input  logic [BYTE_W-1:0] chain_in_i,
  input  logic              cfg_par8_i,
  input  logic              cfg_cap_fall_i,
  input  logic              cfg_qual_inv_i,
  input  logic              cfg_link_en_i,
  input  logic [1:0]        cfg_link_ord_i,
  input  logic              cfg_clr_i,
  output logic [BYTE_W-1:0] dout_o,
  output logic              swap_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  slice_cfg_t        cfg;
  logic              fire;
  logic [BYTE_W-1:0] src_byte;
  logic [BYTE_W-1:0] low_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    cfg.par8     = cfg_par8_i;
    cfg.cap_fall = cfg_cap_fall_i;
    cfg.qual_inv = cfg_qual_inv_i;
    cfg.link_en  = cfg_link_en_i;
    cfg.link_ord = link_ord_e'(cfg_link_ord_i);
  end

  slice_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ext_clk_i  (ext_clk_i),
    .qual_i     (qual_i),
    .cap_fall_i (cfg.cap_fall),
    .qual_inv_i (cfg.qual_inv),
    .fire_o     (fire)
  );

  slice_src_mux #(.BYTE_W(BYTE_W)) u_mux (
    .link_en_i  (cfg.link_en),
    .link_ord_i (cfg.link_ord),
    .pin_i      (pin_data_i),
    .self_i     (low_byte),
    .chain_i    (chain_in_i),
    .byte_o     (src_byte)
  );

  slice_shift_core #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .shift_i    (fire),
    .clr_i      (cfg_clr_i),
    .par8_i     (cfg.par8),
    .byte_in_i  (src_byte),
    .low_byte_o (low_byte),
    .swap_o     (swap_o)
  );

  assign dout_o = low_byte;

endmodule

// File: tb/chain_shift_slice_tb.sv
module chain_shift_slice_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_clk, qual;
  logic [7:0] pin_data, chain_in;
  logic       par8, cap_fall, qual_inv, link_en, clr;
  logic [1:0] link_ord;
  logic [7:0] dout;
  logic       swap;

  int n_chk  = 0;
  int n_fail = 0;
  int swaps  = 0;
  int base;

  always #10 clk = ~clk;  // 50 MHz

  chain_shift_slice u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .qual_i(qual),
    .pin_data_i(pin_data), .chain_in_i(chain_in),
    .cfg_par8_i(par8), .cfg_cap_fall_i(cap_fall), .cfg_qual_inv_i(qual_inv),
    .cfg_link_en_i(link_en), .cfg_link_ord_i(link_ord), .cfg_clr_i(clr),
    .dout_o(dout), .swap_o(swap)
  );

  always @(negedge clk) if (rst_n && swap) swaps++;

  // {pin, qual, expected dout, expected swap}
  localparam logic [17:0] VEC [11] = '{
    {8'h11, 1'b1, 8'h00, 1'b0},
    {8'h22, 1'b1, 8'h00, 1'b0},
    {8'h33, 1'b0, 8'h00, 1'b0},
    {8'h33, 1'b1, 8'h00, 1'b0},
    {8'h44, 1'b1, 8'h00, 1'b1},
    {8'h55, 1'b1, 8'h00, 1'b0},
    {8'h66, 1'b1, 8'h00, 1'b0},
    {8'h77, 1'b1, 8'h00, 1'b0},
    {8'h88, 1'b1, 8'h11, 1'b1},
    {8'h99, 1'b0, 8'h11, 1'b0},
    {8'h99, 1'b1, 8'h22, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse();
    @(negedge clk) ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] pat;
    pat = 32'hA5C3_0F96;
    rst_n = 1'b0; ext_clk = 1'b0; qual = 1'b1; pin_data = '0; chain_in = '0;
    par8 = 1'b1; cap_fall = 1'b0; qual_inv = 1'b0; link_en = 1'b0;
    link_ord = 2'd0; clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 dout", dout, 8'h00);
    chk("R1 swap", swap, 0);

    // vector table: byte mode from pins, qualifier gating, swaps (R2 R4 R5)
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      pin_data = VEC[i][17:10];
      qual     = VEC[i][9];
      base     = swaps;
      pulse();
      chk("R2 dout", dout, VEC[i][8:1]);
      chk("R4 swap", swaps - base, VEC[i][0]);
    end
    qual = 1'b1;

    // R8 self-loop: primary 99443322 rotates its low byte to the top
    link_en = 1'b1; link_ord = 2'd0; pin_data = 8'hEE;
    pulse();
    chk("R8 self", dout, 8'h33);
    pulse();
    chk("R8 self", dout, 8'h44);

    // R9 neighbour chain with pins ignored
    do_clear();
    link_ord = 2'd3;
    base = swaps;
    for (int i = 0; i < 4; i++) begin
      chain_in = 8'hC1 + 8'(i);
      pulse();
    end
    chk("R9 swap", swaps - base, 1);
    chain_in = 8'h00;
    for (int i = 0; i < 4; i++) pulse();
    chk("R9 chain", dout, 8'hC1);
    chain_in = 8'h01;
    pulse();
    chk("R9 chain", dout, 8'hC2);
    link_en = 1'b0; link_ord = 2'd0;

    // R3 single-bit mode, upper pin bits are junk
    do_clear();
    par8 = 1'b0;
    base = swaps;
    for (int i = 0; i < 31; i++) begin
      pin_data = {7'b1010101, pat[i]};
      pulse();
    end
    chk("R3 no swap at 31", swaps - base, 0);
    pin_data = {7'b1010101, pat[31]};
    pulse();
    chk("R3 swap at 32", swaps - base, 1);
    pin_data = 8'hFE;
    for (int i = 0; i < 32; i++) pulse();
    chk("R3 swap count", swaps - base, 2);
    chk("R3 bits", dout, 8'h96);
    par8 = 1'b1;

    // R7 falling-edge capture
    do_clear();
    cap_fall = 1'b1;
    base = swaps;
    for (int i = 0; i < 3; i++) pulse();
    @(negedge clk) ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 rising ignored", swaps - base, 0);
    ext_clk = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 falling shifts", swaps - base, 1);
    cap_fall = 1'b0;

    // R6 inverted qualifier
    do_clear();
    qual_inv = 1'b1; qual = 1'b1; pin_data = 8'h5A;
    base = swaps;
    for (int i = 0; i < 4; i++) pulse();
    chk("R6 high blocked", swaps - base, 0);
    qual = 1'b0;
    for (int i = 0; i < 4; i++) pulse();
    chk("R6 low active", swaps - base, 1);
    qual_inv = 1'b0; qual = 1'b1;

    // R10 clear of words and fill count
    pin_data = 8'h3C;
    for (int i = 0; i < 4; i++) pulse();
    chk("R10 pre", dout, 8'h5A);
    pulse(); pulse();
    do_clear();
    chk("R10 primary", dout, 8'h00);
    base = swaps;
    for (int i = 0; i < 3; i++) pulse();
    chk("R10 count", swaps - base, 0);
    pulse();
    chk("R10 swap", swaps - base, 1);
    chk("R10 shadow", dout, 8'h00);

    finish_up();
  end

endmodule